// File: doc/BRIEF.md
# Packet buffer allocation unit

This block keeps track of a fixed pool of numbered packet buffers for a network controller. A host asks for a buffer with an allocate command. If a buffer is free, the block grants the lowest-numbered one and raises a one-cycle completion pulse. If the pool is empty, a failure flag goes up and the request stays pending. The pending request is granted later, without host action, as soon as a buffer is released. The failure flag drops only at that moment.

The host writes a packet-number register that selects the buffer reached by the transmit data window. The release command also takes its buffer number from this register. Two small queues of packet numbers are visible to the host: a receive queue and a transmit-completion queue. Each shows its head number together with an empty flag. Both are filled from a valid/number push port. The host removes heads with commands, and one of the receive removal commands also returns the buffer to the pool. A reset command returns the allocator to its initial state.

The intended host sequence is: issue allocate, wait for the completion pulse, then read the granted number.

Top module: `pkt_alloc_unit`

## Requirements
- R1: After hardware reset, alloc_failed is 1, alloc_done is 0, alloc_pnum and pnr_q are 0, both queues are empty, both drop counters are 0, and all buffers are free.
- R2: An allocate command (cmd_code 1) with a free buffer takes the lowest-numbered free buffer. One cycle after the command edge, alloc_done is high for exactly that cycle, alloc_failed is 0 and alloc_pnum holds the granted number.
- R3: An allocate command with no free buffer sets alloc_failed to 1, gives no alloc_done, and leaves alloc_pnum at its previous value.
- R4: A pending request is granted in the cycle after a buffer becomes free. alloc_failed stays 1 until that grant and clears together with the alloc_done pulse.
- R5: An allocate command issued while a request is pending replaces it. Only one buffer is granted for the two commands.
- R6: pnr_we loads pnr_wdata into pnr_q on the next edge. The release command (cmd_code 2) frees the buffer numbered pnr_q.
- R7: The reset command (cmd_code 6) frees all buffers, cancels any pending request, sets alloc_failed to 1, clears pnr_q and empties both queues. It wins over a same-cycle pnr_we. The drop counters are kept.
- R8: The receive queue is first-in first-out. rx_head shows the oldest entry while rx_empty is 0.
- R9: cmd_code 3 removes the receive head. cmd_code 4 removes the receive head and also frees the buffer with that number. Either command is ignored when the queue is empty.
- R10: The transmit-completion queue is first-in first-out, with its own txc_empty flag. cmd_code 5 removes its head. It is independent of the receive queue.
- R11: A push into a full queue (QDEPTH entries) is dropped: the queue contents are unchanged and that queue's drop counter rises by one, saturating at its maximum.
- R12: cmd_code is sampled only when cmd_valid is 1. Code 0 and code 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (see R2, R6, R7, R9, R10, R12) |
| pnr_we | input | 1 | Write strobe for the packet-number register |
| pnr_wdata | input | PN_W | Packet number to write |
| pnr_q | output | PN_W | Packet-number register, selects the transmit window buffer |
| alloc_done | output | 1 | One-cycle allocation completion pulse |
| alloc_failed | output | 1 | Allocation not satisfied (pending) |
| alloc_pnum | output | PN_W | Number of the last granted buffer |
| rx_push | input | 1 | Receive queue push strobe |
| rx_push_num | input | PN_W | Packet number pushed into the receive queue |
| txc_push | input | 1 | Transmit-completion queue push strobe |
| txc_push_num | input | PN_W | Packet number pushed into the completion queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_head | output | PN_W | Receive queue head number |
| txc_empty | output | 1 | Completion queue empty |
| txc_head | output | PN_W | Completion queue head number |
| rx_drop_cnt | output | DROP_W | Receive pushes dropped while full |
| txc_drop_cnt | output | DROP_W | Completion pushes dropped while full |

## Verification
The hardest state to reach from the ports is a pending allocation that completes late, with the pool fully used. The stimulus first drains all sixteen buffers with back-to-back allocates and then issues one more, so the request stays pending. That request is then released in three different ways: a register-named release, a second allocate that must not double-grant, and a receive-head removal that frees its buffer. The scoreboard expects exactly one completion for each release. It also checks that the failure flag is still high in the cycle between the release and the grant.

// File: rtl/pa_pkg.sv
// Shared definitions for the packet buffer allocation unit.
package pa_pkg;

    // Host command codes carried on cmd_code.
    typedef enum logic [2:0] {
        PA_CMD_NONE        = 3'd0,
        PA_CMD_ALLOC       = 3'd1,
        PA_CMD_RELEASE     = 3'd2,
        PA_CMD_RX_POP      = 3'd3,
        PA_CMD_RX_POP_FREE = 3'd4,
        PA_CMD_TXC_POP     = 3'd5,
        PA_CMD_RESET       = 3'd6
    } pa_cmd_e;

endpackage

// File: rtl/pa_free_pool.sv
// Free-buffer pool with a single allocation request slot.
// Tracks buffer use in a bitmap and grants the lowest-numbered free buffer.
// A request that cannot be served stays pending. It is granted on the first
// cycle in which the registered bitmap shows a free buffer.
// Assumes at most one request and one release per cycle, and that clr_i
// overrides everything else.
module pa_free_pool #(
    parameter int NUM_PKTS = 16,
    localparam int PN_W = $clog2(NUM_PKTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_i,
    input  logic            clr_i,
    input  logic            rel_i,
    input  logic [PN_W-1:0] rel_num_i,
    output logic            done_o,
    output logic            failed_o,
    output logic [PN_W-1:0] pnum_o
);

    logic [NUM_PKTS-1:0] used_q;
    logic                pending_q;
    logic                any_free;
    logic [PN_W-1:0]     free_idx;
    logic                grant;
    logic [NUM_PKTS-1:0] grant_mask;
    logic [NUM_PKTS-1:0] rel_mask;

    // Priority search for the lowest-numbered free buffer.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_PKTS - 1; i >= 0; i--) begin
            if (!used_q[i]) begin
                any_free = 1'b1;
                free_idx = PN_W'(i);
            end
        end
    end

    // Grant and release one-hot masks for the bitmap update.
    always_comb begin
        grant      = (req_i || pending_q) && any_free;
        grant_mask = NUM_PKTS'(grant) << free_idx;
        rel_mask   = NUM_PKTS'(rel_i) << rel_num_i;
    end

    // Bitmap, pending slot and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            used_q    <= '0;
            pending_q <= 1'b0;
            failed_o  <= 1'b1;
            pnum_o    <= '0;
            done_o    <= 1'b0;
        end else begin
            used_q <= (used_q & ~rel_mask) | grant_mask;
            done_o <= grant;
            if (grant) begin
                pnum_o    <= free_idx;
                failed_o  <= 1'b0;
                pending_q <= 1'b0;
            end else if (req_i) begin
                failed_o  <= 1'b1;
                pending_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pa_pkt_queue.sv
// First-in first-out queue of packet numbers with a drop counter.
// The head is read combinationally from storage. A push into a full queue
// is accepted only if a pop happens in the same cycle. Otherwise it is
// dropped and counted, and the counter saturates.
// Assumes DEPTH is a power of two. flush_i empties the queue but keeps the
// drop count.
module pa_pkt_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    parameter int CNT_W = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     push_num_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic             empty_o,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] drop_o
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          full, do_pop, push_ok;

    // Occupancy flags and accepted-operation strobes.
    always_comb begin
        empty_o = (count == '0);
        full    = (count == (AW+1)'(DEPTH));
        do_pop  = pop_i && !empty_o;
        push_ok = push_i && (!full || do_pop);
        head_o  = mem[rd_ptr];
    end

    // Pointers, occupancy and drop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drop_o <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(push_ok) - (AW+1)'(do_pop);
            if (push_i && !push_ok && (drop_o != {CNT_W{1'b1}}))
                drop_o <= drop_o + 1'b1;
        end
    end

    // Entry storage, written on accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok && !flush_i) mem[wr_ptr] <= push_num_i;
    end

endmodule

// File: rtl/pkt_alloc_unit.sv
// Top of the packet buffer allocation unit.
// Decodes host commands and holds the transmit-window packet-number
// register. It connects the free pool to the receive and transmit-completion
// queues. Removing the receive head with release returns that buffer to the
// pool. Assumes one command per cycle.
module pkt_alloc_unit
    import pa_pkg::*;
#(
    parameter int NUM_PKTS = 16,
    parameter int QDEPTH   = 16,
    parameter int DROP_W   = 8,
    localparam int PN_W    = $clog2(NUM_PKTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              pnr_we,
    input  logic [PN_W-1:0]   pnr_wdata,
    output logic [PN_W-1:0]   pnr_q,
    output logic              alloc_done,
    output logic              alloc_failed,
    output logic [PN_W-1:0]   alloc_pnum,
    input  logic              rx_push,
    input  logic [PN_W-1:0]   rx_push_num,
    input  logic              txc_push,
    input  logic [PN_W-1:0]   txc_push_num,
    output logic              rx_empty,
    output logic [PN_W-1:0]   rx_head,
    output logic              txc_empty,
    output logic [PN_W-1:0]   txc_head,
    output logic [DROP_W-1:0] rx_drop_cnt,
    output logic [DROP_W-1:0] txc_drop_cnt
);

    logic            c_alloc, c_release, c_rx_pop, c_rx_pop_free, c_txc_pop, c_reset;
    logic            rel_en;
    logic [PN_W-1:0] rel_num;

    // Command decode, qualified by the strobe.
    always_comb begin
        c_alloc       = cmd_valid && (cmd_code == PA_CMD_ALLOC);
        c_release     = cmd_valid && (cmd_code == PA_CMD_RELEASE);
        c_rx_pop      = cmd_valid && (cmd_code == PA_CMD_RX_POP);
        c_rx_pop_free = cmd_valid && (cmd_code == PA_CMD_RX_POP_FREE);
        c_txc_pop     = cmd_valid && (cmd_code == PA_CMD_TXC_POP);
        c_reset       = cmd_valid && (cmd_code == PA_CMD_RESET);
    end

    // Release source: the window register, or the receive head being removed.
    always_comb begin
        rel_en  = c_release || (c_rx_pop_free && !rx_empty);
        rel_num = c_release ? pnr_q : rx_head;
    end

    // Transmit-window packet-number register.
    always_ff @(posedge clk) begin
        if (!rst_n || c_reset) pnr_q <= '0;
        else if (pnr_we)       pnr_q <= pnr_wdata;
    end

    pa_free_pool #(.NUM_PKTS(NUM_PKTS)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (c_alloc),
        .clr_i     (c_reset),
        .rel_i     (rel_en),
        .rel_num_i (rel_num),
        .done_o    (alloc_done),
        .failed_o  (alloc_failed),
        .pnum_o    (alloc_pnum)
    );

    pa_pkt_queue #(.DEPTH(QDEPTH), .W(PN_W), .CNT_W(DROP_W)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_push),
        .push_num_i (rx_push_num),
        .pop_i      (c_rx_pop || c_rx_pop_free),
        .flush_i    (c_reset),
        .empty_o    (rx_empty),
        .head_o     (rx_head),
        .drop_o     (rx_drop_cnt)
    );

    pa_pkt_queue #(.DEPTH(QDEPTH), .W(PN_W), .CNT_W(DROP_W)) u_txcq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (txc_push),
        .push_num_i (txc_push_num),
        .pop_i      (c_txc_pop),
        .flush_i    (c_reset),
        .empty_o    (txc_empty),
        .head_o     (txc_head),
        .drop_o     (txc_drop_cnt)
    );

endmodule

// File: rtl/pkt_alloc_unit_chk.sv
// Property checker for pkt_alloc_unit, attached through bind.
// It observes the top-level ports only.
module pkt_alloc_unit_chk #(
    parameter int PN_W   = 4,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic              pnr_we,
    input logic [PN_W-1:0]   pnr_wdata,
    input logic [PN_W-1:0]   pnr_q,
    input logic              alloc_done,
    input logic              alloc_failed,
    input logic              rx_push,
    input logic              rx_empty,
    input logic              txc_empty,
    input logic [DROP_W-1:0] rx_drop_cnt
);

    logic is_reset_cmd;
    assign is_reset_cmd = cmd_valid && (cmd_code == 3'd6);

    AST_DONE_NOT_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> !alloc_failed); // R2

    AST_FAIL_CLEARS_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alloc_failed) |-> alloc_done); // R4

    AST_PNR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pnr_we && !is_reset_cmd) |=> (pnr_q == $past(pnr_wdata))); // R6

    AST_RESET_CMD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset_cmd |=> (alloc_failed && pnr_q == '0 && rx_empty && txc_empty)); // R7

    AST_RX_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !is_reset_cmd) |=> !rx_empty); // R8

    AST_DROP_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop_cnt >= $past(rx_drop_cnt)); // R11

endmodule

bind pkt_alloc_unit pkt_alloc_unit_chk #(.PN_W(PN_W), .DROP_W(DROP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .pnr_we       (pnr_we),
    .pnr_wdata    (pnr_wdata),
    .pnr_q        (pnr_q),
    .alloc_done   (alloc_done),
    .alloc_failed (alloc_failed),
    .rx_push      (rx_push),
    .rx_empty     (rx_empty),
    .txc_empty    (txc_empty),
    .rx_drop_cnt  (rx_drop_cnt)
);

// File: tb/pkt_alloc_unit_bench.sv
// Scoreboard bench for pkt_alloc_unit. Stimulus tasks queue the expected
// granted numbers, and a monitor pops them on each completion pulse.
module pkt_alloc_unit_bench;

    localparam int PN_W   = 4;
    localparam int DROP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_code = '0;
    logic              pnr_we = 1'b0;
    logic [PN_W-1:0]   pnr_wdata = '0;
    logic [PN_W-1:0]   pnr_q;
    logic              alloc_done, alloc_failed;
    logic [PN_W-1:0]   alloc_pnum;
    logic              rx_push = 1'b0, txc_push = 1'b0;
    logic [PN_W-1:0]   rx_push_num = '0, txc_push_num = '0;
    logic              rx_empty, txc_empty;
    logic [PN_W-1:0]   rx_head, txc_head;
    logic [DROP_W-1:0] rx_drop_cnt, txc_drop_cnt;

    int n_checks = 0;
    int n_errors = 0;
    int exp_grants[$];

    always #10 clk = ~clk;

    pkt_alloc_unit u_pkt_alloc_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q),
        .alloc_done(alloc_done), .alloc_failed(alloc_failed), .alloc_pnum(alloc_pnum),
        .rx_push(rx_push), .rx_push_num(rx_push_num),
        .txc_push(txc_push), .txc_push_num(txc_push_num),
        .rx_empty(rx_empty), .rx_head(rx_head), .txc_empty(txc_empty), .txc_head(txc_head),
        .rx_drop_cnt(rx_drop_cnt), .txc_drop_cnt(txc_drop_cnt)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(int code);
        @(negedge clk);
        cmd_code  = 3'(code);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = '0;
    endtask

    task automatic write_pnr(int n);
        @(negedge clk);
        pnr_wdata = PN_W'(n);
        pnr_we    = 1'b1;
        @(negedge clk);
        pnr_we    = 1'b0;
    endtask

    task automatic push_rx(int n);
        @(negedge clk);
        rx_push_num = PN_W'(n);
        rx_push     = 1'b1;
        @(negedge clk);
        rx_push     = 1'b0;
    endtask

    task automatic push_txc(int n);
        @(negedge clk);
        txc_push_num = PN_W'(n);
        txc_push     = 1'b1;
        @(negedge clk);
        txc_push     = 1'b0;
    endtask

    // Monitor: each completion pulse must match the oldest queued grant.
    always @(negedge clk) begin
        if (rst_n && alloc_done) begin
            if (exp_grants.size() == 0) begin
                chk("R5 unexpected alloc_done", 1, 0);
            end else begin
                chk("R2 granted number", int'(alloc_pnum), exp_grants.pop_front());
                chk("R4 failed clear with done", int'(alloc_failed), 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 failed", int'(alloc_failed), 1);
        chk("R1 done", int'(alloc_done), 0);
        chk("R1 pnr", int'(pnr_q), 0);
        chk("R1 pnum", int'(alloc_pnum), 0);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 txc_empty", int'(txc_empty), 1);
        chk("R1 drops", int'(rx_drop_cnt) + int'(txc_drop_cnt), 0);

        // R2 fill the pool in ascending order
        for (int i = 0; i < 16; i++) begin
            exp_grants.push_back(i);
            send_cmd(1);
            chk("R2 failed low", int'(alloc_failed), 0);
            chk("R2 pnum", int'(alloc_pnum), i);
        end

        // R3 exhausted pool
        send_cmd(1);
        chk("R3 failed high", int'(alloc_failed), 1);
        chk("R3 pnum kept", int'(alloc_pnum), 15);
        chk("R3 no done", int'(alloc_done), 0);

        // R6 register write, then R4 release completes the pending request
        write_pnr(5);
        chk("R6 pnr readback", int'(pnr_q), 5);
        exp_grants.push_back(5);
        send_cmd(2);
        chk("R4 still failed before grant", int'(alloc_failed), 1);
        idle(1);
        chk("R4 failed cleared", int'(alloc_failed), 0);
        chk("R4 pnum", int'(alloc_pnum), 5);

        // R5 second allocate while pending gives a single grant
        send_cmd(1);
        send_cmd(1);
        chk("R5 pending failed", int'(alloc_failed), 1);
        write_pnr(9);
        exp_grants.push_back(9);
        send_cmd(2);
        idle(3);
        chk("R5 single grant pnum", int'(alloc_pnum), 9);
        send_cmd(1);
        chk("R5 pool full again", int'(alloc_failed), 1);

        // R8 receive queue order
        push_rx(7);
        push_rx(3);
        push_rx(12);
        chk("R8 rx not empty", int'(rx_empty), 0);
        chk("R8 rx head", int'(rx_head), 7);
        send_cmd(3);
        chk("R9 pop head", int'(rx_head), 3);
        // R9 pop-and-free releases buffer 3 to the pending request
        exp_grants.push_back(3);
        send_cmd(4);
        chk("R9 head after free-pop", int'(rx_head), 12);
        idle(1);
        chk("R9 freed buffer granted", int'(alloc_pnum), 3);
        send_cmd(3);
        chk("R9 rx empty", int'(rx_empty), 1);
        send_cmd(3);
        chk("R9 pop on empty ignored", int'(rx_empty), 1);

        // R10 completion queue
        push_txc(4);
        push_txc(8);
        chk("R10 txc not empty", int'(txc_empty), 0);
        chk("R10 txc head", int'(txc_head), 4);
        chk("R10 rx unaffected", int'(rx_empty), 1);
        send_cmd(5);
        chk("R10 txc head after pop", int'(txc_head), 8);
        send_cmd(5);
        chk("R10 txc empty", int'(txc_empty), 1);

        // R11 overflow drop
        for (int i = 0; i < 17; i++) push_rx(i % 16);
        chk("R11 rx drop count", int'(rx_drop_cnt), 1);
        chk("R11 txc drop count", int'(txc_drop_cnt), 0);
        for (int i = 0; i < 16; i++) begin
            chk("R11 contents kept", int'(rx_head), i);
            send_cmd(3);
        end
        chk("R11 drained", int'(rx_empty), 1);

        // R7 reset command
        push_rx(2);
        write_pnr(6);
        send_cmd(6);
        chk("R7 failed set", int'(alloc_failed), 1);
        chk("R7 pnr cleared", int'(pnr_q), 0);
        chk("R7 rx flushed", int'(rx_empty), 1);
        chk("R7 drop kept", int'(rx_drop_cnt), 1);
        exp_grants.push_back(0);
        send_cmd(1);
        chk("R7 pool all free", int'(alloc_pnum), 0);

        // R12 unused code has no effect
        write_pnr(11);
        send_cmd(7);
        chk("R12 pnr kept", int'(pnr_q), 11);
        chk("R12 failed kept", int'(alloc_failed), 0);
        chk("R12 rx still empty", int'(rx_empty), 1);
        exp_grants.push_back(1);
        send_cmd(1);
        chk("R12 next grant", int'(alloc_pnum), 1);

        idle(2);
        chk("R4 all expected grants seen", exp_grants.size(), 0);
        summary();
        $finish;
    end

endmodule